// File: doc/BRIEF.md
# Word-RAM Ownership Handshake Register

This block holds the memory-mode register that decides who may use a shared word RAM placed between a main processor and a sub processor. Both processors write the same register through their own byte write ports. The block applies each write according to two things: which side wrote it and which mode is active.

There are two modes.
- **Whole mode:** the RAM belongs to one side at a time. A request/return handshake moves ownership between the sides. A request flag (DMNA) is raised by the main side, and a return flag (RET) is raised by the sub side.
- **Split mode:** each side owns one half of the RAM. The return flag picks which half the main side sees, and the sub side sees the other half.

A two-bit copy of the whole-mode handshake state is kept at all times, including while split mode is active. This copy restores the handshake flags when the block goes back to whole mode.

The block drives the mode, the whole-mode owner and the half selection for each side. The RAM data path and any conversion of the RAM layout are outside this block.

Top module: `wram_owner_hs`

## Requirements
- R1: After reset the register reads 0x01: whole mode (bit 2 = 0), RET (bit 0) = 1, DMNA (bit 1) = 0. The tracked handshake state also holds RET = 1 and DMNA = 0, so the main side owns the RAM (`owner_sub` = 0).
- R2: A main-side write changes only the bank field (bits 7:6) and the DMNA path (bit 1). A sub-side write changes only the auxiliary field (bits 4:3), the mode bit (bit 2) and RET (bit 0). Bit 5 always reads 0.
- R3: A main write with bit 1 = 1 sets the tracked DMNA and clears the tracked RET. A sub write with bit 0 = 1 sets the tracked RET and clears the tracked DMNA. Other writes leave the tracked state unchanged.
- R4: In whole mode, the visible DMNA and RET bits equal the tracked state after every write from either side. Writing 0 to them in whole mode does not clear them.
- R5: In whole mode, `owner_sub` is 1 exactly when DMNA = 1 and RET = 0.
- R6: In split mode, a main write with bit 1 = 0 sets visible DMNA. A main write with bit 1 = 1 leaves visible DMNA unchanged.
- R7: In split mode, a sub write that changes the mode bit or RET clears visible DMNA. A sub write that changes neither of them keeps DMNA.
- R8: In split mode, `main_half` equals RET, `sub_half` is its inverse, and `owner_sub` is 0.
- R9: The tracked state keeps following R3 while split mode is active. A sub write that selects whole mode loads DMNA and RET from the tracked state.
- R10: When both sides write in the same cycle, the main write is applied first and the sub write is applied to its result.
- R11: `sub_rd_data` returns the whole register. `main_rd_data` returns the register with the auxiliary field (bits 4:3) read as 0.
- R12: In a cycle with no write, the register and the tracked state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_wr_en | input | 1 | Main-side byte write strobe |
| main_wr_data | input | 8 | Main-side write byte |
| sub_wr_en | input | 1 | Sub-side byte write strobe |
| sub_wr_data | input | 8 | Sub-side write byte |
| main_rd_data | output | 8 | Register as seen by the main side |
| sub_rd_data | output | 8 | Register as seen by the sub side |
| split_mode | output | 1 | 1 = split (half-per-side) mode |
| owner_sub | output | 1 | Whole mode: RAM belongs to the sub side |
| main_half | output | 1 | Split mode: half index mapped to the main side |
| sub_half | output | 1 | Split mode: half index mapped to the sub side |

## Verification
The main write and the sub write can land in the same clock cycle. Each of them can touch the handshake flags, the tracked state and the DMNA bit.

The bench provokes this collision in both modes:
- In whole mode, a request and a return are written together.
- Entering split mode is combined with a main bank write.
- In split mode, a main write that sets DMNA is combined with a sub write that flips RET.

Each result is judged against the order given in R10: the sub write's effect must be what remains. In the last case, this means DMNA is set by the main write and then cleared by the sub write.

// File: rtl/wram_hs_pkg.sv
package wram_hs_pkg;
   localparam int RET_B  = 0;
   localparam int DMNA_B = 1;
   localparam int MODE_B = 2;
   localparam int AUX_LO = 3;

   typedef struct packed {
      logic dmna;
      logic ret;
   } hs_trk_t;

   localparam hs_trk_t TRK_RESET = '{dmna: 1'b0, ret: 1'b1};
endpackage

// File: rtl/wram_hs_main_wr.sv
module wram_hs_main_wr
   import wram_hs_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int BANK_W  = 2,
   parameter int BANK_LO = 6
) (
   input  logic              en,
   input  logic [BANK_W-1:0] bank_d,
   input  logic              dmna_d,
   input  logic [REG_W-1:0]  reg_i,
   input  hs_trk_t           trk_i,
   output logic [REG_W-1:0]  reg_o,
   output hs_trk_t           trk_o
);
   always_comb begin
      reg_o = reg_i;
      trk_o = trk_i;
      if (en) begin
         if (dmna_d) begin
            trk_o.dmna = 1'b1;
            trk_o.ret  = 1'b0;
         end
         reg_o[BANK_LO +: BANK_W] = bank_d;
         if (reg_i[MODE_B]) begin
            // split mode: a zero requests, a one is a no-op
            reg_o[DMNA_B] = reg_i[DMNA_B] | ~dmna_d;
         end else begin
            reg_o[DMNA_B] = trk_o.dmna;
            reg_o[RET_B]  = trk_o.ret;
         end
      end
   end
endmodule

// File: rtl/wram_hs_sub_wr.sv
module wram_hs_sub_wr
   import wram_hs_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int AUX_W = 2
) (
   input  logic             en,
   input  logic [AUX_W-1:0] aux_d,
   input  logic             mode_d,
   input  logic             ret_d,
   input  logic [REG_W-1:0] reg_i,
   input  hs_trk_t          trk_i,
   output logic [REG_W-1:0] reg_o,
   output hs_trk_t          trk_o
);
   logic swap_done;

   always_comb begin
      reg_o = reg_i;
      trk_o = trk_i;
      swap_done = 1'b0;
      if (en) begin
         reg_o[AUX_LO +: AUX_W] = aux_d;
         reg_o[MODE_B] = mode_d;
         reg_o[RET_B]  = ret_d;
         if (ret_d) begin
            trk_o.ret  = 1'b1;
            trk_o.dmna = 1'b0;
         end
         if (mode_d) begin
            swap_done = (reg_i[MODE_B] != mode_d) || (reg_i[RET_B] != ret_d);
            if (swap_done)
               reg_o[DMNA_B] = 1'b0;
         end else begin
            reg_o[DMNA_B] = trk_o.dmna;
            reg_o[RET_B]  = trk_o.ret;
         end
      end
   end
endmodule

// File: rtl/wram_hs_view.sv
module wram_hs_view
   import wram_hs_pkg::*;
#(
   parameter int REG_W         = 8,
   parameter int AUX_W         = 2,
   parameter bit MAIN_SEES_AUX = 1'b0
) (
   input  logic [REG_W-1:0] reg_q,
   output logic [REG_W-1:0] main_rd,
   output logic [REG_W-1:0] sub_rd,
   output logic             split,
   output logic             own_sub,
   output logic             half_main,
   output logic             half_sub
);
   localparam logic [REG_W-1:0] AUX_MASK = {AUX_W{1'b1}} << AUX_LO;

   assign sub_rd    = reg_q;
   assign split     = reg_q[MODE_B];
   assign own_sub   = ~reg_q[MODE_B] & reg_q[DMNA_B] & ~reg_q[RET_B];
   assign half_main = reg_q[RET_B];
   assign half_sub  = ~reg_q[RET_B];

   generate
      if (MAIN_SEES_AUX) begin : g_main_full
         assign main_rd = reg_q;
      end else begin : g_main_masked
         assign main_rd = reg_q & ~AUX_MASK;
      end
   endgenerate
endmodule

// File: rtl/wram_owner_hs.sv
module wram_owner_hs
   import wram_hs_pkg::*;
#(
   parameter int BANK_W        = 2,
   parameter int AUX_W         = 2,
   parameter int PAD_W         = 1,
   parameter bit MAIN_SEES_AUX = 1'b0
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  main_wr_en,
   input  logic [AUX_LO+AUX_W+PAD_W+BANK_W-1:0]  main_wr_data,
   input  logic                                  sub_wr_en,
   input  logic [AUX_LO+AUX_W+PAD_W+BANK_W-1:0]  sub_wr_data,
   output logic [AUX_LO+AUX_W+PAD_W+BANK_W-1:0]  main_rd_data,
   output logic [AUX_LO+AUX_W+PAD_W+BANK_W-1:0]  sub_rd_data,
   output logic                                  split_mode,
   output logic                                  owner_sub,
   output logic                                  main_half,
   output logic                                  sub_half
);
   localparam int REG_W   = AUX_LO + AUX_W + PAD_W + BANK_W;
   localparam int PAD_LO  = AUX_LO + AUX_W;
   localparam int BANK_LO = PAD_LO + PAD_W;
   localparam logic [REG_W-1:0] REG_RESET = REG_W'(1) << RET_B;

   generate
      if (BANK_W < 1) begin : g_chk_bank
         $error("BANK_W must be at least 1");
      end
      if (AUX_W < 1) begin : g_chk_aux
         $error("AUX_W must be at least 1");
      end
      if (PAD_W < 0) begin : g_chk_pad
         $error("PAD_W must not be negative");
      end
   endgenerate

   logic [REG_W-1:0] reg_q, reg_m, reg_n;
   hs_trk_t          trk_q, trk_m, trk_n;

   // main write first, sub write applied on top of it
   wram_hs_main_wr #(.REG_W(REG_W), .BANK_W(BANK_W), .BANK_LO(BANK_LO)) u_main (
      .en     (main_wr_en),
      .bank_d (main_wr_data[BANK_LO +: BANK_W]),
      .dmna_d (main_wr_data[DMNA_B]),
      .reg_i  (reg_q),
      .trk_i  (trk_q),
      .reg_o  (reg_m),
      .trk_o  (trk_m)
   );

   wram_hs_sub_wr #(.REG_W(REG_W), .AUX_W(AUX_W)) u_sub (
      .en     (sub_wr_en),
      .aux_d  (sub_wr_data[AUX_LO +: AUX_W]),
      .mode_d (sub_wr_data[MODE_B]),
      .ret_d  (sub_wr_data[RET_B]),
      .reg_i  (reg_m),
      .trk_i  (trk_m),
      .reg_o  (reg_n),
      .trk_o  (trk_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= REG_RESET;
         trk_q <= TRK_RESET;
      end else begin
         reg_q <= reg_n;
         trk_q <= trk_n;
      end
   end

   wram_hs_view #(.REG_W(REG_W), .AUX_W(AUX_W), .MAIN_SEES_AUX(MAIN_SEES_AUX)) u_view (
      .reg_q     (reg_q),
      .main_rd   (main_rd_data),
      .sub_rd    (sub_rd_data),
      .split     (split_mode),
      .own_sub   (owner_sub),
      .half_main (main_half),
      .half_sub  (sub_half)
   );

   logic unused_wr_bits;
   assign unused_wr_bits = ^{main_wr_data[BANK_LO-1:DMNA_B+1], main_wr_data[RET_B],
                             sub_wr_data[REG_W-1:PAD_LO], sub_wr_data[DMNA_B]};

   AST_WHOLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_q[MODE_B] |-> (reg_q[DMNA_B] == trk_q.dmna && reg_q[RET_B] == trk_q.ret)); // R4

   AST_MAIN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (main_wr_en && !sub_wr_en) |=> $stable(reg_q[BANK_LO-1:MODE_B])); // R2

   AST_SUB_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_wr_en && !main_wr_en) |=> $stable(reg_q[REG_W-1:BANK_LO])); // R2

   AST_SPLIT_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_q[MODE_B] && main_wr_en && !main_wr_data[DMNA_B] && !sub_wr_en) |=> reg_q[DMNA_B]); // R6

   AST_SPLIT_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_q[MODE_B] && main_wr_en && main_wr_data[DMNA_B] && !sub_wr_en)
      |=> reg_q[DMNA_B] == $past(reg_q[DMNA_B])); // R6

   AST_SPLIT_NO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      split_mode |-> !owner_sub); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_wr_en && !sub_wr_en) |=> ($stable(reg_q) && $stable(trk_q))); // R12

   generate
      if (PAD_W > 0) begin : g_pad_chk
         AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            reg_q[PAD_LO +: PAD_W] == '0); // R2
      end
   endgenerate
endmodule

// File: tb/tb_wram_owner_hs.sv
module tb_wram_owner_hs;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_wr_en = 1'b0;
   logic [7:0] main_wr_data = 8'h00;
   logic       sub_wr_en = 1'b0;
   logic [7:0] sub_wr_data = 8'h00;
   logic [7:0] main_rd_data, sub_rd_data;
   logic       split_mode, owner_sub, main_half, sub_half;

   int total = 0;
   int bad = 0;

   logic [7:0] exp_reg_q[$];
   logic       exp_own_q[$];
   string      exp_tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   wram_owner_hs dut (
      .clk(clk), .rst_n(rst_n),
      .main_wr_en(main_wr_en), .main_wr_data(main_wr_data),
      .sub_wr_en(sub_wr_en), .sub_wr_data(sub_wr_data),
      .main_rd_data(main_rd_data), .sub_rd_data(sub_rd_data),
      .split_mode(split_mode), .owner_sub(owner_sub),
      .main_half(main_half), .sub_half(sub_half)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input logic [7:0] er, input logic eo, input string tg);
      chk(sub_rd_data == er, tg, "sub_rd_data", sub_rd_data, er);
      chk(main_rd_data == (er & 8'hE7), {tg, "/R11"}, "main_rd_data", main_rd_data, er & 8'hE7);
      chk(split_mode == er[2], tg, "split_mode", {7'd0, split_mode}, {7'd0, er[2]});
      chk(owner_sub == eo, tg, "owner_sub", {7'd0, owner_sub}, {7'd0, eo});
      if (er[2]) begin
         chk(main_half == er[0] && sub_half == ~er[0], {tg, "/R8"}, "halves",
             {6'd0, main_half, sub_half}, {6'd0, er[0], ~er[0]});
      end
   endtask

   // driver: apply one cycle of stimulus and queue the expectation
   task automatic step(input bit me, input logic [7:0] md, input bit se, input logic [7:0] sd,
                       input logic [7:0] er, input logic eo, input string tg);
      @(negedge clk);
      main_wr_en = me; main_wr_data = md;
      sub_wr_en = se;  sub_wr_data = sd;
      exp_reg_q.push_back(er);
      exp_own_q.push_back(eo);
      exp_tag_q.push_back(tg);
      @(negedge clk);
      main_wr_en = 1'b0; sub_wr_en = 1'b0;
   endtask

   // monitor: register settles at the edge, compare just after it
   always @(posedge clk) begin
      #1;
      if (exp_reg_q.size() > 0) begin
         logic [7:0] er;
         logic       eo;
         string      tg;
         er = exp_reg_q.pop_front();
         eo = exp_own_q.pop_front();
         tg = exp_tag_q.pop_front();
         compare_all(er, eo, tg);
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            compare_all(8'h01, 1'b0, "R1 reset");
            step(0, 8'h00, 0, 8'h00, 8'h01, 0, "R12 idle");
            step(1, 8'h00, 0, 8'h00, 8'h01, 0, "R4 main zero in whole");
            step(1, 8'h02, 0, 8'h00, 8'h02, 1, "R3 R5 main request");
            step(0, 8'h00, 1, 8'h00, 8'h02, 1, "R4 sub zero in whole");
            step(1, 8'hC0, 0, 8'h00, 8'hC2, 1, "R2 main bank");
            step(0, 8'h00, 1, 8'h01, 8'hC1, 0, "R3 sub return");
            step(0, 8'h00, 1, 8'hFF, 8'hDD, 0, "R2 sub all ones enters split");
            step(1, 8'h02, 0, 8'h00, 8'h1D, 0, "R6 main one holds DMNA");
            step(1, 8'h00, 0, 8'h00, 8'h1F, 0, "R6 main zero sets DMNA");
            step(0, 8'h00, 1, 8'h1C, 8'h1C, 0, "R7 RET flip clears DMNA");
            step(1, 8'h00, 0, 8'h00, 8'h1E, 0, "R6 main zero sets DMNA again");
            step(0, 8'h00, 1, 8'h14, 8'h16, 0, "R7 aux-only keeps DMNA");
            step(0, 8'h00, 1, 8'h00, 8'h02, 1, "R9 restore to whole");
            step(1, 8'h02, 1, 8'h01, 8'h01, 0, "R10 request and return together");
            step(1, 8'h40, 1, 8'h05, 8'h45, 0, "R10 bank and enter split");
            step(1, 8'h00, 1, 8'h04, 8'h04, 0, "R10 split set then clear DMNA");
            step(0, 8'h00, 1, 8'h00, 8'h01, 0, "R9 restore RET to whole");
            step(0, 8'h00, 0, 8'h00, 8'h01, 0, "R12 idle hold");
            repeat (3) @(negedge clk);
         end
         begin
            repeat (5000) @(posedge clk);
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule